// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This combinational unit carries out the eight field-manipulation operations of a 64-bit integer datapath. Each operation either pulls a contiguous field out of one register or splices the low bits of one register into a field of another. The execute stage hands it the 32-bit instruction word, the value of the source register and the current value of the destination register. Insert operations need that current value because every bit outside the field is kept. The unit returns the value to write back, a write strobe, a flag for an instruction that is not allowed in the current mode, and a flag for an extract whose field would run past the top of the register.

Two 5-bit fields in the instruction give the field bounds. Each variant biases them by +32 in its own way: on the low bound, on the high bound, or on both. A short encoding can therefore name any field in 64 bits. The two word forms work on the low 32 bits and sign-extend their 32-bit result. The six doubleword forms are only legal when 64-bit operation is enabled.

Top module: `bfx_unit`

## Requirements
- R1: The unit acts only on instructions with bits 31:26 equal to 011111 and bits 5:3 equal to 000; bits 2:0 select the operation. Bits 15:11 hold the high/size field (`hi`) and bits 10:6 hold the low field (`lo`). For any other instruction, `wr_en_o`, `rsvd_o` and `bad_field_o` are 0 and `rt_new_o` equals `rt_old_i`.
- R2: Operation 000 (word extract) takes `hi`+1 bits of the source starting at bit `lo`, with zeros above them. It then copies bit 31 of that 32-bit value into bits 63:32.
- R3: Operation 011 (doubleword extract) returns `hi`+1 bits of the source starting at bit `lo`, zero-extended to 64 bits.
- R4: Operation 001 (extract, long field) returns `hi`+33 bits starting at bit `lo`. Operation 010 (extract, upper start) returns `hi`+1 bits starting at bit `lo`+32. Both are zero-extended.
- R5: An extract writes (`wr_en_o`=1) whenever its start plus its length is at most 64. For the word form the limit is 32. A field that ends exactly at the limit is legal.
- R6: Operation 100 (word insert) replaces bits `hi`..`lo` of the old destination with the low bits of the source. It then sign-extends the 32-bit result from bit 31.
- R7: Doubleword inserts replace the following bit ranges of the old destination with the low bits of the source: operation 111 uses bits `hi`..`lo`, operation 101 uses bits `hi`+32..`lo`, and operation 110 uses bits `hi`+32..`lo`+32.
- R8: For an insert whose lower bound is above its upper bound, `wr_en_o` is 1 and `rt_new_o` equals `rt_old_i` in all 64 bits.
- R9: An insert never changes a bit of the old destination outside its field. Bits of the source above the field length have no effect on the result.
- R10: When `dw_en_i` is 0, the six doubleword operations (001, 010, 011, 101, 110, 111) raise `rsvd_o`, hold `wr_en_o` at 0 and `bad_field_o` at 0, and pass `rt_old_i` through. The word forms are unaffected.
- R11: An extract whose start plus length exceeds its limit (64, or 32 for the word form) raises `bad_field_o` and holds `wr_en_o` at 0, with `rt_new_o` equal to `rt_old_i`. If `rsvd_o` is set, it takes priority and `bad_field_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Source register value |
| rt_old_i | input | 64 | Current destination register value |
| dw_en_i | input | 1 | 64-bit operations enabled |
| rt_new_o | output | 64 | Value to write to the destination |
| wr_en_o | output | 1 | Destination write strobe |
| rsvd_o | output | 1 | Operation not allowed in current mode |
| bad_field_o | output | 1 | Extract field runs past the register |

## Verification
The bench first applies directed patterns for each operation. It uses sources with distinct nibbles, so a field taken from the wrong offset is visible. It uses an all-ones source over a zero destination, and the reverse, to show leakage outside an insert field. It includes fields ending exactly at bit 31 or bit 63 and fields one bit past them. Inverted insert bounds and every doubleword form with 64-bit mode off are also covered. Thousands of pseudo-random encodings then mix legal, oversized, foreign and disabled cases. A behavioural bit-loop model is compared against every result, including the sign-extension boundary.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam logic [5:0]  OPC_FIELD = 6'b011111;

   typedef enum logic [2:0] {
      FN_EXT_W = 3'd0,
      FN_EXT_M = 3'd1,
      FN_EXT_U = 3'd2,
      FN_EXT_D = 3'd3,
      FN_INS_W = 3'd4,
      FN_INS_M = 3'd5,
      FN_INS_U = 3'd6,
      FN_INS_D = 3'd7
   } fld_fn_e;

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
   import bfx_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned POS_W = IDX_W + 1,
   localparam int unsigned HALF  = DATA_W / 2,
   localparam int unsigned FLD_W = $clog2(HALF)
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               dw_en,
   output logic               hit,
   output logic               is_ins,
   output logic               is_word,
   output logic               rsvd,
   output logic               bad,
   output logic               ins_empty,
   output logic [IDX_W-1:0]   ext_pos,
   output logic [POS_W-1:0]   ext_width,
   output logic [IDX_W-1:0]   ins_lower,
   output logic [IDX_W-1:0]   ins_upper
);

   localparam logic [POS_W-1:0] HALF_P = POS_W'(HALF);
   localparam logic [POS_W-1:0] FULL_P = POS_W'(DATA_W);
   localparam logic [POS_W-1:0] ONE_P  = POS_W'(1);

   fld_fn_e          fn;
   logic [POS_W-1:0] lo_x, hi_x;
   logic [POS_W-1:0] pos_x, wid_x, lim_x, low_x, up_x;
   logic             needs_dw;
   logic [9:0]       unused_regs;

   assign unused_regs = instr[25:16];
   assign fn   = fld_fn_e'(instr[2:0]);
   assign lo_x = POS_W'(instr[6 +: FLD_W]);
   assign hi_x = POS_W'(instr[6 + FLD_W +: FLD_W]);
   assign hit  = (instr[31:26] == OPC_FIELD) && (instr[5:3] == 3'b000);

   assign is_ins   = instr[2];
   assign is_word  = (fn == FN_EXT_W) || (fn == FN_INS_W);
   assign needs_dw = !is_word;

   always_comb begin
      pos_x = lo_x;
      wid_x = hi_x + ONE_P;
      lim_x = FULL_P;
      low_x = lo_x;
      up_x  = hi_x;
      case (fn)
         FN_EXT_W: lim_x = HALF_P;
         FN_EXT_M: wid_x = hi_x + ONE_P + HALF_P;
         FN_EXT_U: pos_x = lo_x + HALF_P;
         FN_EXT_D: ;
         FN_INS_W: ;
         FN_INS_M: up_x = hi_x + HALF_P;
         FN_INS_U: begin
            low_x = lo_x + HALF_P;
            up_x  = hi_x + HALF_P;
         end
         FN_INS_D: ;
         default: ;
      endcase
   end

   assign rsvd      = hit && needs_dw && !dw_en;
   assign bad       = hit && !rsvd && !is_ins && ((pos_x + wid_x) > lim_x);
   assign ins_empty = low_x > up_x;
   assign ext_pos   = pos_x[IDX_W-1:0];
   assign ext_width = wid_x;
   assign ins_lower = low_x[IDX_W-1:0];
   assign ins_upper = up_x[IDX_W-1:0];

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned MASK_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  lo,
   input  logic [IDX_W-1:0]  hi,
   output logic [DATA_W-1:0] mask
);

   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   if (MASK_STYLE > 1) begin : g_bad_style
      $error("bfx_mask: MASK_STYLE must be 0 (per-bit compare) or 1 (two shifts)");
   end

   if (MASK_STYLE == 0) begin : g_cmp
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam logic [IDX_W-1:0] IDXV = IDX_W'(i);
         assign mask[i] = (IDXV >= lo) && (IDXV <= hi);
      end
   end else begin : g_shift
      assign mask = ({DATA_W{1'b1}} << lo) & ({DATA_W{1'b1}} >> (TOP_IDX - hi));
   end

endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned HALF  = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src,
   input  logic [IDX_W-1:0]  pos,
   input  logic [DATA_W-1:0] mask,
   input  logic              is_word,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] field;

   assign field = (src >> pos) & mask;
   assign res   = is_word ? {{HALF{field[HALF-1]}}, field[HALF-1:0]} : field;

endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned HALF  = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] old,
   input  logic [IDX_W-1:0]  lower,
   input  logic [DATA_W-1:0] mask,
   input  logic              is_word,
   input  logic              empty,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] merged;

   assign merged = (old & ~mask) | ((src << lower) & mask);

   always_comb begin
      if (empty)
         res = old;
      else if (is_word)
         res = {{HALF{merged[HALF-1]}}, merged[HALF-1:0]};
      else
         res = merged;
   end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned MASK_STYLE = 1
) (
   input  logic [31:0]       instr_i,
   input  logic [DATA_W-1:0] rs_val_i,
   input  logic [DATA_W-1:0] rt_old_i,
   input  logic              dw_en_i,
   output logic [DATA_W-1:0] rt_new_o,
   output logic              wr_en_o,
   output logic              rsvd_o,
   output logic              bad_field_o
);

   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam int unsigned POS_W = IDX_W + 1;
   localparam int unsigned HALF  = DATA_W / 2;

   if (DATA_W < 16 || DATA_W > 64 || (1 << IDX_W) != DATA_W) begin : g_bad_width
      $error("bfx_unit: DATA_W must be a power of two from 16 to 64");
   end
   if (INSTR_W != 32) begin : g_bad_instr
      $error("bfx_unit: instruction layout assumes a 32-bit word");
   end

   logic              hit, is_ins, is_word, rsvd, bad, ins_empty;
   logic [IDX_W-1:0]  ext_pos, ins_lower, ins_upper, m_lo, m_hi;
   logic [POS_W-1:0]  ext_width;
   logic [POS_W-1:0]  ext_top;
   logic [DATA_W-1:0] mask, ext_res, ins_res;

   bfx_decode #(.DATA_W(DATA_W)) u_dec (
      .instr     (instr_i),
      .dw_en     (dw_en_i),
      .hit       (hit),
      .is_ins    (is_ins),
      .is_word   (is_word),
      .rsvd      (rsvd),
      .bad       (bad),
      .ins_empty (ins_empty),
      .ext_pos   (ext_pos),
      .ext_width (ext_width),
      .ins_lower (ins_lower),
      .ins_upper (ins_upper)
   );

   assign ext_top = ext_width - POS_W'(1);
   assign m_lo    = is_ins ? ins_lower : '0;
   assign m_hi    = is_ins ? ins_upper : ext_top[IDX_W-1:0];

   bfx_mask #(.DATA_W(DATA_W), .MASK_STYLE(MASK_STYLE)) u_mask (
      .lo   (m_lo),
      .hi   (m_hi),
      .mask (mask)
   );

   bfx_extract #(.DATA_W(DATA_W)) u_ext (
      .src     (rs_val_i),
      .pos     (ext_pos),
      .mask    (mask),
      .is_word (is_word),
      .res     (ext_res)
   );

   bfx_insert #(.DATA_W(DATA_W)) u_ins (
      .src     (rs_val_i),
      .old     (rt_old_i),
      .lower   (ins_lower),
      .mask    (mask),
      .is_word (is_word),
      .empty   (ins_empty),
      .res     (ins_res)
   );

   assign wr_en_o     = hit && !rsvd && !bad;
   assign rsvd_o      = rsvd;
   assign bad_field_o = bad;
   assign rt_new_o    = !wr_en_o ? rt_old_i : (is_ins ? ins_res : ext_res);

   always_comb begin
      if (instr_i[31:26] != OPC_FIELD) begin
         AST_FOREIGN_QUIET: assert (!wr_en_o && !rsvd_o && !bad_field_o && rt_new_o == rt_old_i)
            else $error("foreign instruction touched outputs"); // R1
      end
      if (rsvd_o) begin
         AST_RSVD_NO_WRITE: assert (!wr_en_o && !bad_field_o && rt_new_o == rt_old_i)
            else $error("disabled doubleword op wrote"); // R10
      end
      if (bad_field_o) begin
         AST_BAD_NO_WRITE: assert (!wr_en_o && rt_new_o == rt_old_i)
            else $error("oversized extract wrote"); // R11
      end
      if (wr_en_o && !is_ins && !is_word) begin
         AST_EXT_HIGH_ZERO: assert ((rt_new_o >> ext_width) == '0)
            else $error("extract left bits above field"); // R3
      end
      if (wr_en_o && is_word && !ins_empty) begin
         AST_WORD_SEXT: assert (rt_new_o[DATA_W-1:HALF] == {HALF{rt_new_o[HALF-1]}})
            else $error("word result not sign-extended"); // R2
      end
      if (wr_en_o && is_ins && !is_word) begin
         AST_INS_OUTSIDE_KEPT: assert (((rt_new_o ^ rt_old_i) & ~mask) == '0)
            else $error("insert changed bits outside field"); // R9
      end
   end

endmodule

// File: tb/test_bfx_unit.sv
`timescale 1ns/1ps
module test_bfx_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr;
   logic [63:0] rs_val, rt_old, rt_new;
   logic        dw_en, wr_en, rsvd, bad;
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;

   always #4 clk = ~clk;

   bfx_unit i_bfx_unit (
      .instr_i     (instr),
      .rs_val_i    (rs_val),
      .rt_old_i    (rt_old),
      .dw_en_i     (dw_en),
      .rt_new_o    (rt_new),
      .wr_en_o     (wr_en),
      .rsvd_o      (rsvd),
      .bad_field_o (bad)
   );

   function automatic logic [31:0] mk(input int fn, input int hi, input int lo);
      logic [4:0] h5, l5;
      logic [2:0] f3;
      h5 = hi[4:0];
      l5 = lo[4:0];
      f3 = fn[2:0];
      return {6'b011111, 5'd3, 5'd7, h5, l5, 3'b000, f3};
   endfunction

   task automatic model(input logic [31:0] ins, input logic [63:0] rs, input logic [63:0] rt,
                        input logic en, output logic [63:0] ert, output logic ewe,
                        output logic ersvd, output logic ebad, output string tag);
      int fn, hi, lo, st, len, lim, lower, upper;
      logic [63:0] v;
      ert = rt; ewe = 0; ersvd = 0; ebad = 0; tag = "R1";
      fn = int'(ins[2:0]); hi = int'(ins[15:11]); lo = int'(ins[10:6]);
      if (ins[31:26] != 6'b011111 || ins[5:3] != 3'b000) return;
      if (fn != 0 && fn != 4 && !en) begin
         ersvd = 1; tag = "R10"; return;
      end
      if (fn < 4) begin
         st = lo; len = hi + 1; lim = 64;
         case (fn)
            0: begin lim = 32; tag = "R2"; end
            1: begin len = hi + 33; tag = "R4"; end
            2: begin st = lo + 32; tag = "R4"; end
            default: tag = "R3";
         endcase
         if (st + len > lim) begin
            ebad = 1; tag = "R11"; return;
         end
         v = '0;
         for (int k = 0; k < len; k++) v[k] = rs[st + k];
         if (fn == 0) for (int k = 32; k < 64; k++) v[k] = v[31];
         ert = v; ewe = 1;
      end else begin
         lower = lo; upper = hi; tag = (fn == 4) ? "R6" : "R7";
         if (fn == 5) upper = hi + 32;
         if (fn == 6) begin lower = lo + 32; upper = hi + 32; end
         ewe = 1;
         if (lower > upper) begin
            tag = "R8"; return;
         end
         v = rt;
         for (int k = lower; k <= upper; k++) v[k] = rs[k - lower];
         if (fn == 4) for (int k = 32; k < 64; k++) v[k] = v[31];
         ert = v;
      end
   endtask

   task automatic apply(input logic [31:0] ins, input logic [63:0] rs, input logic [63:0] rt,
                        input logic en, input string force_tag);
      logic [63:0] ert;
      logic ewe, ersvd, ebad;
      string tag;
      @(negedge clk);
      instr = ins; rs_val = rs; rt_old = rt; dw_en = en;
      model(ins, rs, rt, en, ert, ewe, ersvd, ebad, tag);
      if (force_tag != "") tag = force_tag;
      @(posedge clk);
      #1;
      n_tests++;
      if (rt_new !== ert || wr_en !== ewe || rsvd !== ersvd || bad !== ebad) begin
         n_fail++;
         $display("FAIL %s instr=%h: got rt=%h we=%b rsvd=%b bad=%b, expected rt=%h we=%b rsvd=%b bad=%b",
                  tag, ins, rt_new, wr_en, rsvd, bad, ert, ewe, ersvd, ebad);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] pat;
      pat = 64'h0123_4567_89AB_CDEF;
      instr = '0; rs_val = '0; rt_old = '0; dw_en = 1'b1;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R1: idle word and foreign encodings
      apply(32'h0, pat, 64'hDEAD_BEEF_0000_1111, 1, "R1");
      apply({6'b000000, mk(3, 5, 2)} >> 0 & 32'h03FF_FFFF, pat, 64'h55, 1, "R1");
      apply(mk(0, 7, 4) | 32'h0000_0020, pat, 64'hAA, 1, "R1");
      // R2 word extract, plain and sign boundary
      apply(mk(0, 7, 4), pat, 64'h0, 1, "R2");
      apply(mk(0, 7, 24), 64'h0000_0000_F100_0000, 64'h0, 1, "R2");
      apply(mk(0, 7, 24), pat, 64'h0, 0, "R2");
      // R3 doubleword extract
      apply(mk(3, 31, 0), pat, 64'h0, 1, "R3");
      apply(mk(3, 31, 8), {pat[31:0], pat[63:32]}, 64'h0, 1, "R3");
      // R4 long and upper extracts
      apply(mk(1, 3, 4), pat, 64'h0, 1, "R4");
      apply(mk(2, 15, 8), pat, 64'h0, 1, "R4");
      // R5 fields ending exactly at the limit
      apply(mk(0, 0, 31), 64'h8000_0000, 64'h0, 1, "R5");
      apply(mk(1, 0, 31), 64'hFFFF_FFFF_8000_0000, 64'h0, 1, "R5");
      apply(mk(2, 0, 31), 64'h8000_0000_0000_0000, 64'h0, 1, "R5");
      // R6 word insert
      apply(mk(4, 15, 8), 64'hFFFF_FFFF_FFFF_FF5A, 64'h1111_2222_3333_4444, 1, "R6");
      apply(mk(4, 31, 16), 64'h0000_0000_0000_FFFF, 64'h0, 1, "R6");
      // R7 doubleword inserts
      apply(mk(7, 19, 4), pat, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7");
      apply(mk(5, 3, 28), pat, 64'h0, 1, "R7");
      apply(mk(6, 31, 0), pat, 64'h0, 1, "R7");
      // R8 inverted bounds
      apply(mk(4, 3, 10), pat, 64'h8765_4321_FEDC_BA98, 1, "R8");
      apply(mk(6, 5, 20), pat, 64'h8765_4321_FEDC_BA98, 1, "R8");
      // R9 no leakage outside the field
      apply(mk(7, 11, 4), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, "R9");
      apply(mk(7, 11, 4), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R9");
      apply(mk(6, 7, 4), 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 1, "R9");
      // R10 doubleword forms disabled
      for (int f = 1; f < 8; f++)
         if (f != 4) apply(mk(f, 2, 1), pat, 64'h1234, 0, "R10");
      // R11 oversized extracts
      apply(mk(0, 15, 20), pat, 64'h77, 1, "R11");
      apply(mk(3, 30, 40 - 32), pat, 64'h77, 1, "R3");
      apply(mk(2, 1, 31), pat, 64'h77, 1, "R11");
      apply(mk(1, 1, 31), pat, 64'h77, 1, "R11");
      apply(mk(1, 31, 31), pat, 64'h77, 0, "R10");
      // mixed pseudo-random sweep
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] ins;
         ins = $urandom();
         if (n % 8 != 0) begin
            ins[31:26] = 6'b011111;
            if (n % 16 != 1) ins[5:3] = 3'b000;
         end
         apply(ins, {$urandom(), $urandom()}, {$urandom(), $urandom()}, (n % 5) != 0, "");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule